// File: doc/BRIEF.md
# Linear Access Page-Split Checker

This unit sits between address generation and translation in a load/store pipeline. It takes one linear memory request: a 64-bit address, a byte count from 1 to 64, the current privilege level, a 64-bit-mode flag, an enable for half-space separation, an enable for alignment checking, and an alignment mask. It then decides whether the request may proceed. A request that breaks an address rule is turned into a single fault code. A legal request becomes one or two page-local pieces. Each piece gives the address where it starts, how many bytes it covers, and, for the second piece, where its bytes begin inside the request data. The request data is taken as little-endian.

The checks run in a fixed order. First the address must be canonical and must lie in the correct half of the address space. Then a user request must be aligned. Last, the request is split at a 4 KiB page boundary if it crosses one. When a split happens in 64-bit mode, the start of the second piece is checked again. Outside 64-bit mode, the start of the second piece wraps to 32 bits.

Requests and results each use a valid/ready handshake. The result is registered one cycle after a request is accepted. It stays unchanged until the consumer takes it.

Top module: `lin_split_chk`

## Requirements
- R1: A request is a user request only when `reqPl` equals 3. Levels 0, 1 and 2 are supervisor requests for every check below.
- R2: If address bits 63 down to 47 are not all equal, the result is `resFault` = 1 and `resCount` = 0.
- R3: When `reqMode64` and `sepEn` are both 1, a request is rejected with `resFault` = 1 and `resCount` = 0 if address bit 63 equals the user flag. This covers a user request to an address with bit 63 = 1 and a supervisor request to an address with bit 63 = 0.
- R4: When `sepEn` is 0 or `reqMode64` is 0, the bit-63 half-space rule has no effect on the result.
- R5: When `alignEn` is 1 and the request is a user request, a nonzero AND of address bits 11:0 with `alignMask` gives `resFault` = 2 and `resCount` = 0. Supervisor requests are never rejected for alignment.
- R6: When (address bits 11:0) + length ≤ 4096, the result is `resFault` = 0 and `resCount` = 1, with `d0Addr` equal to the request address and `d0Len` equal to the request length. The first piece always starts at request byte 0.
- R7: When (address bits 11:0) + length > 4096, the result is `resCount` = 2. The fields are:
  - `d0Len` = 4096 − (address bits 11:0)
  - `d1Len` = length − `d0Len`
  - `d1Addr` = address + `d0Len`
  - `d1Off` = `d0Len`
- R8: When `reqMode64` is 0, `d1Addr` keeps only the low 32 bits of address + `d0Len`. The upper 32 bits are zero.
- R9: When `reqMode64` is 1 and a split second address fails the rule of R2 or the rule of R3, the result is `resFault` = 3 and `resCount` = 0.
- R10: When several faults apply, code 1 takes precedence over code 2, and code 2 over code 3. Fault codes: 0 none, 1 first-address rule, 2 alignment, 3 second-address rule.
- R11: `reqReady` = !`resValid` || `resReady`. An accepted request gives `resValid` = 1 at the next clock edge. While `resValid` = 1 and `resReady` = 0, every result output holds its value.
- R12: After reset, `resValid` is 0 and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqAddr | input | 64 | Linear start address |
| reqLen | input | 7 | Byte count, 1 to 64 |
| reqPl | input | 2 | Current privilege level |
| reqMode64 | input | 1 | 64-bit mode active |
| sepEn | input | 1 | Half-space separation enabled |
| alignEn | input | 1 | Alignment checking enabled |
| alignMask | input | 12 | Mask ANDed with the page offset |
| resValid | output | 1 | Result present |
| resReady | input | 1 | Consumer takes the result |
| resFault | output | 2 | Fault code, 0 when none |
| resCount | output | 2 | Number of pieces, 0 to 2 |
| d0Addr | output | 64 | First piece address |
| d0Len | output | 7 | First piece length |
| d1Addr | output | 64 | Second piece address |
| d1Len | output | 7 | Second piece length |
| d1Off | output | 7 | Byte index in the request where the second piece starts |

## Verification
The design holds little internal state: one occupancy bit and the captured result. A wrong occupancy bit shows at the ports on the very next edge. It appears either as a result that was lost, because `reqReady` was high while a result was still held, or as a handshake stuck with `reqReady` low. A wrong decision is captured on the accept edge and shows in the following cycle. It may appear as a wrong fault code, as pieces whose lengths do not reach the page end, or as a second address that was not wrapped. A wrong decision cannot stay hidden across requests, because each result replaces the previous one in full.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ADDR  = 2'd1,
    FLT_ALIGN = 2'd2,
    FLT_ADDR2 = 2'd3
  } fault_e;

  typedef struct packed {
    logic load;
  } ctl_strobe_t;
endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        resReady,
  output logic        reqReady,
  output logic        resValid,
  output ctl_strobe_t strobe
);
  logic full;

  assign reqReady    = !full || resReady;
  assign resValid    = full;
  assign strobe.load = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= 1'b0;
    end else if (strobe.load) begin
      full <= 1'b1;
    end else if (resReady) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_W      = 48,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [1:0]           reqPl,
  input  logic                 reqMode64,
  input  logic                 sepEn,
  input  logic                 alignEn,
  input  logic [PAGE_BITS-1:0] alignMask,
  output logic [1:0]           resFault,
  output logic [1:0]           resCount,
  output logic [ADDR_W-1:0]    d0Addr,
  output logic [LEN_W-1:0]     d0Len,
  output logic [ADDR_W-1:0]    d1Addr,
  output logic [LEN_W-1:0]     d1Len,
  output logic [LEN_W-1:0]     d1Off
);
  localparam int SUM_W     = PAGE_BITS + 1;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int HI_W      = ADDR_W - VA_W + 1;

  function automatic logic isCanon(input logic [ADDR_W-1:0] a);
    logic [HI_W-1:0] upper;
    upper = a[ADDR_W-1:VA_W-1];
    return (&upper) || !(|upper);
  endfunction

  logic                 isUser;
  logic [PAGE_BITS-1:0] pageOff;
  logic [SUM_W-1:0]     endSum;
  logic                 crosses;
  logic [LEN_W-1:0]     firstLen;
  logic [ADDR_W-1:0]    secRaw;
  logic [ADDR_W-1:0]    secAddr;
  logic                 badFirst;
  logic                 badAlign;
  logic                 badSecond;
  fault_e               faultNext;

  assign isUser   = (reqPl == 2'd3);
  assign pageOff  = reqAddr[PAGE_BITS-1:0];
  assign endSum   = {1'b0, pageOff} + SUM_W'(reqLen);
  assign crosses  = endSum > SUM_W'(PAGE_SIZE);
  assign firstLen = LEN_W'(0) - pageOff[LEN_W-1:0];
  assign secRaw   = reqAddr + ADDR_W'(firstLen);

  generate
    if (ADDR_W > 32) begin : g_wrap
      assign secAddr = reqMode64 ? secRaw : {{(ADDR_W-32){1'b0}}, secRaw[31:0]};
    end else begin : g_nowrap
      assign secAddr = secRaw;
    end
  endgenerate

  assign badFirst  = !isCanon(reqAddr) ||
                     (reqMode64 && sepEn && (reqAddr[ADDR_W-1] == isUser));
  assign badAlign  = alignEn && isUser && (|(pageOff & alignMask));
  assign badSecond = crosses && reqMode64 &&
                     (!isCanon(secAddr) || (sepEn && (secAddr[ADDR_W-1] == isUser)));

  always_comb begin
    if (badFirst)       faultNext = FLT_ADDR;
    else if (badAlign)  faultNext = FLT_ALIGN;
    else if (badSecond) faultNext = FLT_ADDR2;
    else                faultNext = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resFault <= 2'd0;
      resCount <= 2'd0;
      d0Addr   <= '0;
      d0Len    <= '0;
      d1Addr   <= '0;
      d1Len    <= '0;
      d1Off    <= '0;
    end else if (strobe.load) begin
      resFault <= faultNext;
      if (faultNext != FLT_NONE) begin
        resCount <= 2'd0;
        d0Addr   <= '0;
        d0Len    <= '0;
        d1Addr   <= '0;
        d1Len    <= '0;
        d1Off    <= '0;
      end else if (crosses) begin
        resCount <= 2'd2;
        d0Addr   <= reqAddr;
        d0Len    <= firstLen;
        d1Addr   <= secAddr;
        d1Len    <= reqLen - firstLen;
        d1Off    <= firstLen;
      end else begin
        resCount <= 2'd1;
        d0Addr   <= reqAddr;
        d0Len    <= reqLen;
        d1Addr   <= '0;
        d1Len    <= '0;
        d1Off    <= '0;
      end
    end
  end
endmodule

// File: rtl/lin_split_chk.sv
module lin_split_chk
  import lsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_W      = 48,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [1:0]           reqPl,
  input  logic                 reqMode64,
  input  logic                 sepEn,
  input  logic                 alignEn,
  input  logic [PAGE_BITS-1:0] alignMask,
  output logic                 resValid,
  input  logic                 resReady,
  output logic [1:0]           resFault,
  output logic [1:0]           resCount,
  output logic [ADDR_W-1:0]    d0Addr,
  output logic [LEN_W-1:0]     d0Len,
  output logic [ADDR_W-1:0]    d1Addr,
  output logic [LEN_W-1:0]     d1Len,
  output logic [LEN_W-1:0]     d1Off
);
  ctl_strobe_t strobe;

  lsc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .resReady (resReady),
    .reqReady (reqReady),
    .resValid (resValid),
    .strobe   (strobe)
  );

  lsc_datapath #(
    .ADDR_W    (ADDR_W),
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .LEN_W     (LEN_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqPl     (reqPl),
    .reqMode64 (reqMode64),
    .sepEn     (sepEn),
    .alignEn   (alignEn),
    .alignMask (alignMask),
    .resFault  (resFault),
    .resCount  (resCount),
    .d0Addr    (d0Addr),
    .d0Len     (d0Len),
    .d1Addr    (d1Addr),
    .d1Len     (d1Len),
    .d1Off     (d1Off)
  );
endmodule

// File: rtl/lin_split_chk_checker.sv
module lin_split_chk_checker #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              resValid,
  input logic              resReady,
  input logic [1:0]        resFault,
  input logic [1:0]        resCount,
  input logic [ADDR_W-1:0] d0Addr,
  input logic [LEN_W-1:0]  d0Len,
  input logic [ADDR_W-1:0] d1Addr,
  input logic [LEN_W-1:0]  d1Len,
  input logic [LEN_W-1:0]  d1Off
);
  localparam int SUM_W     = PAGE_BITS + 1;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;

  logic [SUM_W-1:0] firstEnd;
  assign firstEnd = {1'b0, d0Addr[PAGE_BITS-1:0]} + SUM_W'(d0Len);

  // R11
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> resValid);

  // R11
  held_result_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resFault) && $stable(resCount) &&
      $stable(d0Addr) && $stable(d0Len) && $stable(d1Addr) && $stable(d1Len) && $stable(d1Off)));

  // R11
  ready_when_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> reqReady);

  // R10
  fault_no_pieces_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resFault != 2'd0) |-> (resCount == 2'd0));

  // R6
  single_in_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCount == 2'd1) |-> (firstEnd <= SUM_W'(PAGE_SIZE)));

  // R7
  split_reaches_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCount == 2'd2) |->
      (firstEnd == SUM_W'(PAGE_SIZE) && d1Off == d0Len && d1Len != '0 &&
       d1Addr[PAGE_BITS-1:0] == '0));
endmodule

bind lin_split_chk lin_split_chk_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS),
  .LEN_W     (LEN_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .resValid (resValid),
  .resReady (resReady),
  .resFault (resFault),
  .resCount (resCount),
  .d0Addr   (d0Addr),
  .d0Len    (d0Len),
  .d1Addr   (d1Addr),
  .d1Len    (d1Len),
  .d1Off    (d1Off)
);

// File: tb/lin_split_chk_tb_top.sv
module lin_split_chk_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqAddr = '0;
  logic [6:0]  reqLen = 7'd1;
  logic [1:0]  reqPl = 2'd0;
  logic        reqMode64 = 1'b1;
  logic        sepEn = 1'b0;
  logic        alignEn = 1'b0;
  logic [11:0] alignMask = '0;
  logic        resValid;
  logic        resReady = 1'b1;
  logic [1:0]  resFault;
  logic [1:0]  resCount;
  logic [63:0] d0Addr;
  logic [6:0]  d0Len;
  logic [63:0] d1Addr;
  logic [6:0]  d1Len;
  logic [6:0]  d1Off;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_split_chk dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqPl(reqPl), .reqMode64(reqMode64),
    .sepEn(sepEn), .alignEn(alignEn), .alignMask(alignMask),
    .resValid(resValid), .resReady(resReady), .resFault(resFault),
    .resCount(resCount), .d0Addr(d0Addr), .d0Len(d0Len), .d1Addr(d1Addr),
    .d1Len(d1Len), .d1Off(d1Off)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic canon(input logic [63:0] a);
    return (a[63:47] == 17'h0) || (a[63:47] == 17'h1ffff);
  endfunction

  // Expected result derived from the requirement text
  task automatic model(input logic [63:0] a, input logic [6:0] n, input logic [1:0] pl,
                       input logic m64, input logic sep, input logic aen,
                       input logic [11:0] msk, output logic [1:0] f, output logic [1:0] c,
                       output logic [6:0] l0, output logic [63:0] a1,
                       output logic [6:0] l1);
    logic user;
    int off;
    logic [63:0] s;
    user = (pl == 2'd3);
    off = int'(a[11:0]);
    f = 2'd0; c = 2'd0; l0 = '0; a1 = '0; l1 = '0;
    if (!canon(a) || (m64 && sep && (a[63] == user))) f = 2'd1;
    else if (aen && user && ((a[11:0] & msk) != 0)) f = 2'd2;
    else if (off + int'(n) <= 4096) begin
      c = 2'd1; l0 = n;
    end else begin
      l0 = 7'(4096 - off);
      s = a + 64'(4096 - off);
      if (!m64) s = {32'h0, s[31:0]};
      if (m64 && (!canon(s) || (sep && (s[63] == user)))) f = 2'd3;
      else begin
        c = 2'd2; a1 = s; l1 = n - l0;
      end
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [6:0] n, input logic [1:0] pl,
                       input logic m64, input logic sep, input logic aen,
                       input logic [11:0] msk);
    reqAddr = a; reqLen = n; reqPl = pl; reqMode64 = m64;
    sepEn = sep; alignEn = aen; alignMask = msk;
  endtask

  task automatic compare(input string tag, input logic [63:0] a, input logic [6:0] n,
                         input logic [1:0] pl, input logic m64, input logic sep,
                         input logic aen, input logic [11:0] msk);
    logic [1:0] ef, ec;
    logic [6:0] el0, el1;
    logic [63:0] ea1;
    model(a, n, pl, m64, sep, aen, msk, ef, ec, el0, ea1, el1);
    chk(resValid == 1'b1, {tag, " resValid"}, 64'(resValid), 64'd1);
    chk(resFault == ef, {tag, " resFault"}, 64'(resFault), 64'(ef));
    chk(resCount == ec, {tag, " resCount"}, 64'(resCount), 64'(ec));
    if (ec != 2'd0) begin
      chk(d0Addr == a, {tag, " d0Addr"}, d0Addr, a);
      chk(d0Len == el0, {tag, " d0Len"}, 64'(d0Len), 64'(el0));
    end
    if (ec == 2'd2) begin
      chk(d1Addr == ea1, {tag, " d1Addr"}, d1Addr, ea1);
      chk(d1Len == el1, {tag, " d1Len"}, 64'(d1Len), 64'(el1));
      chk(d1Off == el0, {tag, " d1Off"}, 64'(d1Off), 64'(el0));
    end
  endtask

  // One accepted request with the consumer always ready
  task automatic run_req(input string tag, input logic [63:0] a, input logic [6:0] n,
                         input logic [1:0] pl, input logic m64, input logic sep,
                         input logic aen, input logic [11:0] msk);
    @(negedge clk);
    drive(a, n, pl, m64, sep, aen, msk);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    compare(tag, a, n, pl, m64, sep, aen, msk);
  endtask

  task automatic t_reset();
    chk(resValid == 1'b0, "R12 resValid", 64'(resValid), 64'd0);
    chk(reqReady == 1'b1, "R12 reqReady", 64'(reqReady), 64'd1);
  endtask

  task automatic t_single();
    run_req("R6 mid page", 64'h0000_0000_1000_0100, 7'd8, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    run_req("R6 exact end", 64'h0000_0000_0000_2FC0, 7'd64, 2'd3, 1'b1, 1'b0, 1'b0, 12'h0);
    run_req("R6 high half", 64'hFFFF_8000_0000_0010, 7'd1, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
  endtask

  task automatic t_split();
    run_req("R7 even split", 64'h0000_0000_0000_0FF0, 7'd32, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    run_req("R7 one byte over", 64'h0000_0012_3456_7FC1, 7'd64, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    chk(d1Len == 7'd1, "R7 d1Len literal", 64'(d1Len), 64'd1);
  endtask

  task automatic t_wrap();
    run_req("R8 wrap", 64'h0000_0000_FFFF_FFF8, 7'd16, 2'd0, 1'b0, 1'b0, 1'b0, 12'h0);
    chk(d1Addr == 64'h0, "R8 d1Addr literal", d1Addr, 64'h0);
  endtask

  task automatic t_canon();
    run_req("R2 bit48", 64'h0001_0000_0000_0000, 7'd4, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    run_req("R2 bit47 only", 64'h0000_8000_0000_0000, 7'd4, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    chk(resFault == 2'd1, "R2 literal", 64'(resFault), 64'd1);
  endtask

  task automatic t_sep();
    run_req("R3 user to high", 64'hFFFF_8000_0000_0000, 7'd4, 2'd3, 1'b1, 1'b1, 1'b0, 12'h0);
    run_req("R3 super to low", 64'h0000_0000_0000_1000, 7'd4, 2'd0, 1'b1, 1'b1, 1'b0, 12'h0);
    run_req("R3 user to low", 64'h0000_0000_0000_1000, 7'd4, 2'd3, 1'b1, 1'b1, 1'b0, 12'h0);
    run_req("R1 pl2 high ok", 64'hFFFF_8000_0000_0000, 7'd4, 2'd2, 1'b1, 1'b1, 1'b0, 12'h0);
    run_req("R1 pl2 low bad", 64'h0000_0000_0000_1000, 7'd4, 2'd2, 1'b1, 1'b1, 1'b0, 12'h0);
    run_req("R4 sep off", 64'h0000_0000_0000_1000, 7'd4, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    run_req("R4 not 64-bit", 64'h0000_0000_0000_1000, 7'd4, 2'd0, 1'b0, 1'b1, 1'b0, 12'h0);
    chk(resFault == 2'd0, "R4 literal", 64'(resFault), 64'd0);
  endtask

  task automatic t_align();
    run_req("R5 user odd", 64'h0000_0000_0000_1003, 7'd4, 2'd3, 1'b1, 1'b0, 1'b1, 12'h007);
    chk(resFault == 2'd2, "R5 literal", 64'(resFault), 64'd2);
    run_req("R5 super odd", 64'h0000_0000_0000_1003, 7'd4, 2'd0, 1'b1, 1'b0, 1'b1, 12'h007);
    run_req("R1 pl1 odd", 64'h0000_0000_0000_1003, 7'd4, 2'd1, 1'b1, 1'b0, 1'b1, 12'h007);
    run_req("R5 user aligned", 64'h0000_0000_0000_1008, 7'd4, 2'd3, 1'b1, 1'b0, 1'b1, 12'h007);
    run_req("R5 check off", 64'h0000_0000_0000_1003, 7'd4, 2'd3, 1'b1, 1'b0, 1'b0, 12'h007);
  endtask

  task automatic t_second();
    run_req("R9 second noncanon", 64'h0000_7FFF_FFFF_FFF8, 7'd16, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    chk(resFault == 2'd3, "R9 literal", 64'(resFault), 64'd3);
    run_req("R9 legacy no check", 64'h0000_7FFF_FFFF_FFF8, 7'd16, 2'd0, 1'b0, 1'b0, 1'b0, 12'h0);
    run_req("R10 addr over align", 64'h0001_0000_0000_0003, 7'd4, 2'd3, 1'b1, 1'b0, 1'b1, 12'h003);
    run_req("R10 align over second", 64'h0000_7FFF_FFFF_FFF9, 7'd16, 2'd3, 1'b1, 1'b0, 1'b1, 12'h001);
    chk(resFault == 2'd2, "R10 literal", 64'(resFault), 64'd2);
  endtask

  task automatic t_hold();
    logic [63:0] firstA;
    firstA = 64'h0000_0000_0000_0FF8;
    @(negedge clk);
    resReady = 1'b0;
    drive(firstA, 7'd16, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R11 first", firstA, 7'd16, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    drive(64'h0000_0000_0000_0100, 7'd2, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    chk(reqReady == 1'b0, "R11 ready low while held", 64'(reqReady), 64'd0);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(d0Addr == firstA, "R11 held d0Addr", d0Addr, firstA);
    chk(d1Len == 7'd8, "R11 held d1Len", 64'(d1Len), 64'd8);
    resReady = 1'b1;
    #1;
    chk(reqReady == 1'b1, "R11 ready with consumer", 64'(reqReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    compare("R11 second", 64'h0000_0000_0000_0100, 7'd2, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0);
    @(posedge clk);
    @(negedge clk);
    chk(resValid == 1'b0, "R11 drained", 64'(resValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_wrap();
    t_canon();
    t_sep();
    t_align();
    t_second();
    t_hold();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule